// File: doc/BRIEF.md
# Character Pattern Row Fetch

This block turns a character code and a row number into the five pixels of one row of a character cell. Codes whose upper nibble is zero take their pattern from a small user-writable pattern store holding four glyphs of eight rows each. All other codes take it from a fixed pattern table. The fixed table is a placeholder: either a computed stub or a flat table passed in as a parameter.

The last row of the cell is the cursor row. When the display controller raises the cursor input for that position, every pixel of that row is forced on. Pixels already stored as on in that row stay on either way. A host write port loads the user pattern store one row at a time. The fetched row appears on the output register one clock after the code and row are presented.

Top module: `crf_row_fetch`

## Requirements
- R1: While reset is low, `pix_o` is 0. Reset also clears every row of the user pattern store to 0.
- R2: `pix_o` is registered. It reflects the `code_i`, `row_i` and `cursor_i` sampled at the previous rising clock edge and does not change between edges.
- R3: When `code_i[7:4]` is 0, the row comes from the user pattern store at glyph `code_i[1:0]`, row `row_i`.
- R4: For user codes, `code_i[3:2]` has no effect. Codes 0x00, 0x04, 0x08 and 0x0C give the same row, and likewise for each of the other three glyphs.
- R5: When `code_i[7:4]` is nonzero, the row comes from the fixed table. The default computed stub gives `((code_i[3:0]*5 + row_i*3 + 1) mod 32)`.
- R6: A write with `wr_en_i` high stores `wr_data_i[4:0]` at glyph `wr_addr_i[4:3]`, row `wr_addr_i[2:0]`. Bits 7:5 of `wr_data_i` are discarded. A pixel bit of 1 means on.
- R7: On row 7, with `cursor_i` high, `pix_o` is the stored row ORed with 5'b11111. This holds for both sources. With `cursor_i` low, stored 1s on row 7 are still shown.
- R8: On rows 0 to 6, `cursor_i` has no effect on `pix_o`.
- R9: A fetch in the same cycle as a write to the same slot returns the old content. The new content appears on the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_i | input | 8 | Character code to fetch |
| row_i | input | 3 | Row within the cell, 7 is the cursor row |
| cursor_i | input | 1 | Cursor present at this position |
| wr_en_i | input | 1 | Write strobe for the user pattern store |
| wr_addr_i | input | 5 | Write address: glyph in bits 4:3, row in bits 2:0 |
| wr_data_i | input | 8 | Write data, only bits 4:0 are kept |
| pix_o | output | 5 | Fetched row of pixels, 1 = on |

## Verification
The hardest case to reach from the ports is a write and a fetch landing on the same slot in the same cycle. This is most likely to go wrong when it involves a user code that aliases through bits 3:2 and the cursor row. Purely random codes rarely hit the 16 user codes, so the random stream draws half its codes from 0x00 to 0x0F and half from the full range. Directed sequences then set up the same-cycle write-and-fetch case and cursor overlays on rows already holding on pixels.

// File: rtl/crf_pkg.sv
package crf_pkg;

   typedef enum logic {SRC_ROM = 1'b0, SRC_RAM = 1'b1} crf_src_e;

   // Placeholder fixed-table content, used when no table is supplied
   function automatic int stub_row(input int idx, input int row);
      return idx * 5 + row * 3 + 1;
   endfunction

endpackage

// File: rtl/crf_src_select.sv
module crf_src_select #(
   parameter int CODE_W    = 8,
   parameter int SEL_LSB   = 4,
   parameter int UPAT_W    = 2,
   parameter int ROM_IDX_W = 4
) (
   input  logic [CODE_W-1:0]    code_i,
   output crf_pkg::crf_src_e    src_o,
   output logic [UPAT_W-1:0]    pat_o,
   output logic [ROM_IDX_W-1:0] rom_idx_o
);
   if (SEL_LSB >= CODE_W) begin : g_bad_sel
      $error("SEL_LSB must be below CODE_W");
   end
   if (UPAT_W > SEL_LSB) begin : g_bad_pat
      $error("UPAT_W must fit below SEL_LSB");
   end

   always_comb begin
      src_o     = (code_i[CODE_W-1:SEL_LSB] == '0) ? crf_pkg::SRC_RAM : crf_pkg::SRC_ROM;
      pat_o     = code_i[UPAT_W-1:0];
      rom_idx_o = code_i[ROM_IDX_W-1:0];
   end
endmodule

// File: rtl/crf_pattern_ram.sv
module crf_pattern_ram #(
   parameter int UPAT_W = 2,
   parameter int ROW_W  = 3,
   parameter int PIX_W  = 5,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [UPAT_W+ROW_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   input  logic [UPAT_W+ROW_W-1:0] rd_addr_i,
   output logic [PIX_W-1:0]        rd_data_o
);
   localparam int DEPTH = 1 << (UPAT_W + ROW_W);

   if (DATA_W < PIX_W) begin : g_bad_data
      $error("DATA_W must cover PIX_W");
   end

   logic [PIX_W-1:0] mem [DEPTH];
   logic             live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         live_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         if (wr_en_i) mem[wr_addr_i] <= wr_data_i[PIX_W-1:0];
      end
   end

   assign rd_data_o = mem[rd_addr_i];

   // R6: a completed write is visible on the read port at that address
   a_r6_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(wr_en_i) && rd_addr_i == $past(wr_addr_i))
         |-> rd_data_o == $past(wr_data_i[PIX_W-1:0]));
endmodule

// File: rtl/crf_rom_stub.sv
module crf_rom_stub #(
   parameter int ROM_IDX_W = 4,
   parameter int ROW_W     = 3,
   parameter int PIX_W     = 5,
   parameter int ROM_MODE  = 0,
   parameter logic [(1<<ROM_IDX_W)*(1<<ROW_W)*PIX_W-1:0] ROM_TBL = '0
) (
   input  logic [ROM_IDX_W-1:0] idx_i,
   input  logic [ROW_W-1:0]     row_i,
   output logic [PIX_W-1:0]     row_o
);
   localparam int ROWS = 1 << ROW_W;

   if (ROM_MODE == 0) begin : g_computed
      always_comb row_o = PIX_W'(crf_pkg::stub_row(int'(idx_i), int'(row_i)));
   end else if (ROM_MODE == 1) begin : g_table
      always_comb row_o = ROM_TBL[(int'(idx_i) * ROWS + int'(row_i)) * PIX_W +: PIX_W];
   end else begin : g_bad_mode
      $error("ROM_MODE must be 0 or 1");
   end
endmodule

// File: rtl/crf_row_fetch.sv
module crf_row_fetch #(
   parameter int CODE_W    = 8,
   parameter int SEL_LSB   = 4,
   parameter int ROW_W     = 3,
   parameter int PIX_W     = 5,
   parameter int DATA_W    = 8,
   parameter int UPAT_W    = 2,
   parameter int ROM_IDX_W = 4,
   parameter int ROM_MODE  = 0,
   parameter logic [(1<<ROM_IDX_W)*(1<<ROW_W)*PIX_W-1:0] ROM_TBL = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CODE_W-1:0]       code_i,
   input  logic [ROW_W-1:0]        row_i,
   input  logic                    cursor_i,
   input  logic                    wr_en_i,
   input  logic [UPAT_W+ROW_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   output logic [PIX_W-1:0]        pix_o
);
   localparam int WA_W = UPAT_W + ROW_W;
   localparam logic [ROW_W-1:0] CURSOR_ROW = ROW_W'((1 << ROW_W) - 1);

   if (ROM_IDX_W > CODE_W) begin : g_bad_rom
      $error("ROM_IDX_W must not exceed CODE_W");
   end

   crf_pkg::crf_src_e    src;
   logic [UPAT_W-1:0]    pat;
   logic [ROM_IDX_W-1:0] rom_idx;
   logic [PIX_W-1:0]     ram_row, rom_row, row_next;
   logic                 live_q;

   crf_src_select #(.CODE_W(CODE_W), .SEL_LSB(SEL_LSB), .UPAT_W(UPAT_W),
                    .ROM_IDX_W(ROM_IDX_W)) u_sel (
      .code_i(code_i), .src_o(src), .pat_o(pat), .rom_idx_o(rom_idx));

   crf_pattern_ram #(.UPAT_W(UPAT_W), .ROW_W(ROW_W), .PIX_W(PIX_W),
                     .DATA_W(DATA_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_addr_i(WA_W'({pat, row_i})), .rd_data_o(ram_row));

   crf_rom_stub #(.ROM_IDX_W(ROM_IDX_W), .ROW_W(ROW_W), .PIX_W(PIX_W),
                  .ROM_MODE(ROM_MODE), .ROM_TBL(ROM_TBL)) u_rom (
      .idx_i(rom_idx), .row_i(row_i), .row_o(rom_row));

   always_comb begin
      row_next = (src == crf_pkg::SRC_RAM) ? ram_row : rom_row;
      if (cursor_i && row_i == CURSOR_ROW) row_next = row_next | {PIX_W{1'b1}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_o  <= '0;
         live_q <= 1'b0;
      end else begin
         pix_o  <= row_next;
         live_q <= 1'b1;
      end
   end

   // R7: cursor on the last row lights every pixel
   a_r7_cursor_full: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(cursor_i) && $past(row_i) == CURSOR_ROW) |-> pix_o == {PIX_W{1'b1}});
   // R3: user codes off the cursor row take the user store row
   a_r3_ram_source: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(code_i[CODE_W-1:SEL_LSB]) == '0 && $past(row_i) != CURSOR_ROW)
         |-> pix_o == $past(ram_row));
   // R5: other codes off the cursor row take the fixed table row
   a_r5_rom_source: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(code_i[CODE_W-1:SEL_LSB]) != '0 && $past(row_i) != CURSOR_ROW)
         |-> pix_o == $past(rom_row));
   // R2: output only moves at a clock edge after reset
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $stable(code_i) && $stable(row_i) && $stable(cursor_i) && !$past(wr_en_i))
         |=> $stable(pix_o) || !$stable(code_i) || !$stable(row_i) || !$stable(cursor_i)
             || $past(wr_en_i));
endmodule

// File: tb/sim_crf_row_fetch.sv
module sim_crf_row_fetch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] code_i = 8'h20;
   logic [2:0] row_i = '0;
   logic       cursor_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [4:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [4:0] pix_o;

   int checks = 0;
   int errs = 0;
   logic [4:0] model [32];

   always #2 clk = ~clk;

   crf_row_fetch u0 (.clk(clk), .rst_n(rst_n), .code_i(code_i), .row_i(row_i),
      .cursor_i(cursor_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .pix_o(pix_o));

   function automatic logic [4:0] exp_row(input logic [7:0] c, input logic [2:0] r,
                                          input logic cur);
      logic [4:0] v;
      if (c[7:4] == 4'h0) v = model[{c[1:0], r}];
      else v = 5'(int'(c[3:0]) * 5 + int'(r) * 3 + 1);
      if (cur && r == 3'd7) v = 5'h1F;
      return v;
   endfunction

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
      model[a] = d[4:0];
   endtask

   task automatic fetch(input string req, input logic [7:0] c, input logic [2:0] r,
                        input logic cur);
      @(negedge clk);
      code_i = c; row_i = r; cursor_i = cur;
      @(negedge clk);
      chk(req, pix_o, exp_row(c, r, cur));
   endtask

   initial begin
      #(4 * 200000);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [4:0] old_v;
      void'($urandom(32'd4242));
      for (int i = 0; i < 32; i++) model[i] = '0;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 reset output", pix_o, 5'h00);
      rst_n = 1'b1;
      fetch("R1 cleared store", 8'h00, 3'd3, 1'b0);
      fetch("R1 cleared store", 8'h03, 3'd6, 1'b0);
      // R3 user source
      for (int r = 0; r < 8; r++) wr(5'({2'd1, 3'(r)}), 8'(r * 3 + 2));
      fetch("R3 user glyph1 row2", 8'h01, 3'd2, 1'b0);
      fetch("R3 user glyph1 row5", 8'h01, 3'd5, 1'b0);
      // R4 aliases
      fetch("R4 alias 05", 8'h05, 3'd2, 1'b0);
      fetch("R4 alias 09", 8'h09, 3'd4, 1'b0);
      fetch("R4 alias 0D", 8'h0D, 3'd6, 1'b0);
      wr(5'h00, 8'h15);
      fetch("R4 alias 0C", 8'h0C, 3'd0, 1'b0);
      // R6 high data bits discarded
      wr(5'h14, 8'hE0);
      fetch("R6 high bits dropped", 8'h02, 3'd4, 1'b0);
      wr(5'h1B, 8'hFF);
      fetch("R6 full row", 8'h03, 3'd3, 1'b0);
      // R5 fixed table
      fetch("R5 rom 10", 8'h10, 3'd0, 1'b0);
      fetch("R5 rom 41", 8'h41, 3'd6, 1'b0);
      fetch("R5 rom FF", 8'hFF, 3'd5, 1'b0);
      // R7 cursor row
      wr(5'h0F, 8'h04);
      fetch("R7 cursor off keeps stored", 8'h01, 3'd7, 1'b0);
      fetch("R7 cursor on user", 8'h01, 3'd7, 1'b1);
      fetch("R7 cursor on rom", 8'h7A, 3'd7, 1'b1);
      // R8 cursor elsewhere ignored
      fetch("R8 cursor row3 user", 8'h01, 3'd3, 1'b1);
      fetch("R8 cursor row0 rom", 8'h33, 3'd0, 1'b1);
      // R2 latency: input change before the edge does not move the output
      fetch("R2 setup", 8'h01, 3'd1, 1'b0);
      @(negedge clk);
      code_i = 8'h55; row_i = 3'd2;
      #1;
      chk("R2 holds before edge", pix_o, exp_row(8'h01, 3'd1, 1'b0));
      @(negedge clk);
      chk("R2 updates after edge", pix_o, exp_row(8'h55, 3'd2, 1'b0));
      // R9 same-cycle write and fetch
      old_v = model[5'h0A];
      @(negedge clk);
      code_i = 8'h09; row_i = 3'd2; cursor_i = 1'b0;
      wr_en_i = 1'b1; wr_addr_i = 5'h0A; wr_data_i = 8'h1E;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R9 old content same cycle", pix_o, old_v);
      model[5'h0A] = 5'h1E;
      @(negedge clk);
      chk("R9 new content next fetch", pix_o, 5'h1E);
      // random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 3 == 0) begin
            wr(5'($urandom), 8'($urandom));
         end else begin
            logic [7:0] c;
            c = ($urandom % 2 == 0) ? 8'($urandom % 16) : 8'($urandom);
            fetch("R3/R5/R7/R8 random", c, 3'($urandom), 1'($urandom));
         end
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule